// File: doc/BRIEF.md
# Watchdog Timer with Early Warning

This block is a watchdog that runs on its own slow clock and raises a one-cycle system reset pulse when software does not service it in time. Software sets a time-out period and an early-warning point as power-of-two codes. It can also turn on a closed window, and servicing the watchdog inside that window counts as a fault. The early warning sets a flag, which drives a single interrupt line when the interrupt is enabled.

A sticky always-on bit keeps the counter running whatever the enable bit holds. While it is set, the period, window and warning codes are frozen. The window-enable bit and the interrupt enables stay writable. Only the block's power-on reset input clears the always-on bit.

Access is through a plain synchronous register port with 3-bit addresses, 8-bit write data and a registered read port. Crossing between clock domains and the system reset controller sit outside the block.

Top module: `wdg_guard`

## Requirements
- R1: After `rst` every register reads zero, and `irq` and `sys_rst` are low. The registers are: address 0 control, address 1 timing, address 2 warning, addresses 3 and 4 read the interrupt enable in bit 0, address 5 reads the flag in bit 0.
- R2: When control bit 0 (run) and control bit 2 (always-on) are both zero, the counter holds at zero and neither a reset pulse nor an early-warning flag is produced.
- R3: While counting, `sys_rst` pulses high for exactly one cycle when 8<<P cycles have elapsed since the period started. P is timing bits [3:0]. The period then restarts from zero.
- R4: The early-warning flag sets 8<<W cycles after the period starts, where W is warning register bits [3:0]. If 8<<W is not less than 8<<P, the flag is never set.
- R5: Writing a value with bit 0 set has these effects: at address 3 it enables the interrupt, at address 4 it disables it, and at address 5 it clears the flag. `irq` follows flag AND enable one cycle later.
- R6: While counting, a write of 0xA5 to address 6 restarts the period. Any other value written there pulses `sys_rst` on the next edge. While idle, writes to address 6 have no effect.
- R7: Control bit 1 turns on window mode. In window mode, a 0xA5 write that arrives before 8<<C cycles of the period have elapsed pulses `sys_rst`, where C is timing bits [7:4].
- R8: Writing one to control bit 2 sets always-on. After that, writing zero to the bit does not clear it, and the counter runs regardless of control bit 0. Writes to the timing and warning registers are ignored, while control bit 1 and the interrupt enable stay writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for `addr` |
| irq | output | 1 | Early-warning interrupt request |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
The bench predicts the cycle of each reset pulse from the write cycle and compares every pulse against that prediction. An off-by-one counter therefore shows up as a pulse one cycle early or late. A kick that failed to restart the count would produce an extra pulse, and a wrong key that went unpunished would leave an expected pulse missing. In window mode, a premature kick must reset while a late one must not, so a window compare on the wrong side of the boundary is caught. Three always-on cases are also probed: clearing the bit by writing zero, a frozen period that still changes, and window-enable or interrupt-enable writes that are wrongly locked. Each of these is visible in readback or in the timing of the next pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CODE_W = 4;

  localparam logic [ADDR_W-1:0] A_CTL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_TIMING = 3'd1;
  localparam logic [ADDR_W-1:0] A_WARN   = 3'd2;
  localparam logic [ADDR_W-1:0] A_IE_SET = 3'd3;
  localparam logic [ADDR_W-1:0] A_IE_CLR = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd5;
  localparam logic [ADDR_W-1:0] A_KICK   = 3'd6;

  typedef struct packed {
    logic              run;
    logic              wen;
    logic              aon;
    logic [CODE_W-1:0] per_code;
    logic [CODE_W-1:0] win_code;
    logic [CODE_W-1:0] warn_code;
  } wdg_cfg_t;

  // cycles for a code: 8 shifted left by the code
  function automatic logic [31:0] code_cycles(input logic [CODE_W-1:0] code);
    return 32'd8 << code;
  endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_VAL = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ie_q,
  input  logic              flag_q,
  output wdg_cfg_t          cfg,
  output logic [DATA_W-1:0] rdata,
  output logic              ie_set_wr,
  output logic              ie_clr_wr,
  output logic              flag_clr_wr,
  output logic              kick_wr,
  output logic              kick_ok
);

  localparam int PAD_CTL  = DATA_W - 3;
  localparam int PAD_WARN = DATA_W - CODE_W;
  localparam int PAD_BIT  = DATA_W - 1;

  logic wr_ctl, wr_timing, wr_warn;

  always_comb begin
    wr_ctl      = wr_en && (addr == A_CTL);
    wr_timing   = wr_en && (addr == A_TIMING) && !cfg.aon;
    wr_warn     = wr_en && (addr == A_WARN) && !cfg.aon;
    ie_set_wr   = wr_en && (addr == A_IE_SET) && wdata[0];
    ie_clr_wr   = wr_en && (addr == A_IE_CLR) && wdata[0];
    flag_clr_wr = wr_en && (addr == A_FLAG) && wdata[0];
    kick_wr     = wr_en && (addr == A_KICK);
    kick_ok     = (wdata == KEY_VAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (wr_ctl) begin
        cfg.run <= wdata[0];
        cfg.wen <= wdata[1];
        cfg.aon <= cfg.aon | wdata[2];
      end
      if (wr_timing) begin
        cfg.per_code <= wdata[CODE_W-1:0];
        cfg.win_code <= wdata[2*CODE_W-1:CODE_W];
      end
      if (wr_warn) begin
        cfg.warn_code <= wdata[CODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (addr)
        A_CTL:    rdata <= {{PAD_CTL{1'b0}}, cfg.aon, cfg.wen, cfg.run};
        A_TIMING: rdata <= {cfg.win_code, cfg.per_code};
        A_WARN:   rdata <= {{PAD_WARN{1'b0}}, cfg.warn_code};
        A_IE_SET,
        A_IE_CLR: rdata <= {{PAD_BIT{1'b0}}, ie_q};
        A_FLAG:   rdata <= {{PAD_BIT{1'b0}}, flag_q};
        default:  rdata <= '0;
      endcase
    end
  end

  AST_AON_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg.aon |=> cfg.aon); // R8
  AST_TIMING_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cfg.aon |=> ($stable(cfg.per_code) && $stable(cfg.win_code) && $stable(cfg.warn_code))); // R8

endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wdg_cfg_t cfg,
  input  logic     kick_wr,
  input  logic     kick_ok,
  output logic     warn_hit,
  output logic     sys_rst
);

  localparam int CNT_W = 3 + (1 << CODE_W);

  logic             running;
  logic [CNT_W-1:0] cnt, cnt_inc, cnt_d;
  logic [CNT_W-1:0] per_cyc, win_cyc, warn_cyc;
  logic             fault_d;

  always_comb begin
    running  = cfg.run | cfg.aon;
    per_cyc  = CNT_W'(code_cycles(cfg.per_code));
    win_cyc  = CNT_W'(code_cycles(cfg.win_code));
    warn_cyc = CNT_W'(code_cycles(cfg.warn_code));
    cnt_inc  = cnt + 1'b1;
    cnt_d    = cnt;
    fault_d  = 1'b0;
    warn_hit = 1'b0;
    if (!running) begin
      cnt_d = '0;
    end else if (kick_wr) begin
      cnt_d   = '0;
      fault_d = !kick_ok || (cfg.wen && (cnt < win_cyc));
    end else if (cnt_inc >= per_cyc) begin
      cnt_d   = '0;
      fault_d = 1'b1;
    end else begin
      cnt_d    = cnt_inc;
      warn_hit = (cnt_inc == warn_cyc);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sys_rst <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      sys_rst <= fault_d && !sys_rst;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !running |=> (cnt == '0 && !sys_rst)); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> !sys_rst); // R3
  AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> (cnt == '0)); // R3
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (rst)
    (running && kick_wr && !kick_ok && !sys_rst) |=> sys_rst); // R6

endmodule

// File: rtl/wdg_irq.sv
module wdg_irq (
  input  logic clk,
  input  logic rst,
  input  logic warn_hit,
  input  logic ie_set_wr,
  input  logic ie_clr_wr,
  input  logic flag_clr_wr,
  output logic ie_q,
  output logic flag_q,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (ie_set_wr)      ie_q <= 1'b1;
      else if (ie_clr_wr) ie_q <= 1'b0;
      if (warn_hit)         flag_q <= 1'b1;
      else if (flag_clr_wr) flag_q <= 1'b0;
      irq <= flag_q & ie_q;
    end
  end

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    !ie_q |=> !irq); // R5
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_wr && !warn_hit) |=> !flag_q); // R5

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter logic [7:0] KEY_VAL = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       sys_rst
);

  wdg_cfg_t cfg;
  logic ie_q, flag_q, warn_hit;
  logic ie_set_wr, ie_clr_wr, flag_clr_wr, kick_wr, kick_ok;

  wdg_regs #(.KEY_VAL(KEY_VAL)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .ie_q        (ie_q),
    .flag_q      (flag_q),
    .cfg         (cfg),
    .rdata       (rdata),
    .ie_set_wr   (ie_set_wr),
    .ie_clr_wr   (ie_clr_wr),
    .flag_clr_wr (flag_clr_wr),
    .kick_wr     (kick_wr),
    .kick_ok     (kick_ok)
  );

  wdg_core u_core (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .kick_wr  (kick_wr),
    .kick_ok  (kick_ok),
    .warn_hit (warn_hit),
    .sys_rst  (sys_rst)
  );

  wdg_irq u_irq (
    .clk         (clk),
    .rst         (rst),
    .warn_hit    (warn_hit),
    .ie_set_wr   (ie_set_wr),
    .ie_clr_wr   (ie_clr_wr),
    .flag_clr_wr (flag_clr_wr),
    .ie_q        (ie_q),
    .flag_q      (flag_q),
    .irq         (irq)
  );

endmodule

// File: tb/wdg_guard_bench.sv
`timescale 1ns/1ps
module wdg_guard_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, sys_rst;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int pulses = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdg_guard u_wdg_guard (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .sys_rst(sys_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: every reset pulse must match the next predicted cycle
  always @(negedge clk) begin
    if (!rst && sys_rst) begin
      int e;
      pulses++;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R3/R6/R7 unexpected reset pulse actual=%0d expected=none", cyc);
      end else begin
        e = exp_q.pop_front();
        if (e != cyc) begin
          failures++;
          $display("FAIL R3/R6/R7 reset pulse cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d, output int stamp);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    stamp = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int k, kk, k2, s, p0;
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(sys_rst == 1'b0, "R1 sys_rst", sys_rst, 0);
    rd(3'd0, v); chk(v == 8'h00, "R1 control", v, 0);
    rd(3'd1, v); chk(v == 8'h00, "R1 timing", v, 0);
    rd(3'd5, v); chk(v == 8'h00, "R1 flag", v, 0);

    // R2 idle: no pulses; R6 bad kick ignored while idle
    p0 = pulses;
    repeat (60) @(negedge clk);
    wr(3'd6, 8'h00, s);
    repeat (5) @(negedge clk);
    chk(pulses == p0, "R2 idle pulses", pulses, p0);
    rd(3'd5, v); chk(v == 8'h00, "R2 idle flag", v, 0);

    // R3/R4/R5 normal time-out with early warning
    wr(3'd1, 8'h02, s);
    wr(3'd2, 8'h01, s);
    wr(3'd3, 8'h01, s);
    wr(3'd0, 8'h01, k);
    exp_q.push_back(k + 32);
    wait_until(k + 16); chk(irq == 1'b0, "R5 irq lag", irq, 0);
    wait_until(k + 17); chk(irq == 1'b1, "R4 warning at offset", irq, 1);
    wait_until(k + 34);
    wr(3'd0, 8'h00, s);
    wr(3'd5, 8'h01, s);
    @(negedge clk); chk(irq == 1'b0, "R5 flag clear drops irq", irq, 0);
    rd(3'd5, v); chk(v == 8'h00, "R5 flag cleared", v, 0);

    // R6 good kick restarts the period
    wr(3'd0, 8'h01, k);
    wait_until(k + 20);
    wr(3'd6, 8'hA5, kk);
    exp_q.push_back(kk + 32);
    wait_until(kk + 34);
    wr(3'd0, 8'h00, s);

    // R6 wrong key resets at once
    wr(3'd0, 8'h01, k);
    repeat (10) @(negedge clk);
    wr(3'd6, 8'h5A, kk);
    exp_q.push_back(kk);
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h00, s);

    // R7 window mode: early kick resets, late kick restarts
    wr(3'd1, 8'h12, s);
    wr(3'd0, 8'h03, k);
    repeat (5) @(negedge clk);
    wr(3'd6, 8'hA5, kk);
    exp_q.push_back(kk);
    wait_until(kk + 20);
    wr(3'd6, 8'hA5, k2);
    exp_q.push_back(k2 + 32);
    wait_until(k2 + 33);
    wr(3'd0, 8'h00, s);
    chk(exp_q.size() == 0, "R7 window pulses consumed", exp_q.size(), 0);

    // R4 offset not below period: warning lost
    wr(3'd5, 8'h01, s);
    wr(3'd1, 8'h02, s);
    wr(3'd2, 8'h03, s);
    wr(3'd0, 8'h01, k);
    exp_q.push_back(k + 32);
    wait_until(k + 40);
    wr(3'd0, 8'h00, s);
    rd(3'd5, v); chk(v == 8'h00, "R4 warning lost", v, 0);

    // R5 masked interrupt then enable
    wr(3'd4, 8'h01, s);
    wr(3'd2, 8'h00, s);
    wr(3'd0, 8'h01, k);
    exp_q.push_back(k + 32);
    wait_until(k + 12); chk(irq == 1'b0, "R5 masked irq", irq, 0);
    rd(3'd5, v); chk(v == 8'h01, "R5 flag set while masked", v, 1);
    wait_until(k + 34);
    wr(3'd0, 8'h00, s);
    wr(3'd3, 8'h01, s);
    @(negedge clk); chk(irq == 1'b1, "R5 enable raises irq", irq, 1);
    wr(3'd5, 8'h01, s);

    // R8 always-on
    wr(3'd1, 8'h04, s);
    wr(3'd2, 8'h02, s);
    wr(3'd0, 8'h04, k);
    exp_q.push_back(k + 128);
    wr(3'd1, 8'h00, s);
    rd(3'd1, v); chk(v == 8'h04, "R8 timing locked", v, 4);
    wr(3'd2, 8'h05, s);
    rd(3'd2, v); chk(v == 8'h02, "R8 warning locked", v, 2);
    wr(3'd0, 8'h00, s);
    rd(3'd0, v); chk(v == 8'h04, "R8 sticky bit", v, 4);
    wr(3'd0, 8'h02, s);
    rd(3'd0, v); chk(v == 8'h06, "R8 window enable writable", v, 6);
    wr(3'd4, 8'h01, s);
    rd(3'd3, v); chk(v == 8'h00, "R8 interrupt enable writable", v, 0);
    wait_until(k + 130);
    chk(exp_q.size() == 0, "R8 runs without enable", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule